// File: doc/BRIEF.md
# Range Clamp and Dynamic Expansion

This block sits on the output side of a display pipe and conditions a stream of pixels, each carrying several colour channels of 12 bits. It works in two registered steps. The first step may widen data of a lower bit depth, carried in the upper bits of each 12-bit channel, back to a full 12-bit code. It does this by copying the top bits of the value into the low bits that have no meaning. The second step may hold each channel inside a limited video range. That range is the 16..235 window of 8-bit video, scaled to a chosen depth.

Widening runs only when the caller asks for it and the connector type is one that allows it. Each pixel is paired with the control inputs present in the cycle it is accepted, so controls can change from one pixel to the next. A pixel appears at the output exactly two cycles after it enters. Between pixels the output holds its last value.

Top module: `range_clamp_expand`

## Requirements
- R1: While reset is asserted, and after its release until the first pixel emerges, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and every accepted pixel emerges once, in order.
- R3: With widening active and `exp_mode` = 1 (8-bit source), the 8-bit value v is taken from bits 11:4 of each channel. The result is v in bits 11:4 and v[7:4] in bits 3:0, so 0xFF maps to 0xFFF.
- R4: With widening active and `exp_mode` = 0 (10-bit source, also the setting for 12-bit sources), the 10-bit value v is taken from bits 11:2. The result is v in bits 11:2 and v[9:8] in bits 1:0, so the two low input bits are always replaced.
- R5: Widening is active only when `exp_en` = 1 and `link_kind` is 1 (HDMI), 2 (DisplayPort single stream), 3 (DisplayPort multi-stream) or 4 (virtual). For link codes 0, 5, 6 and 7, or when `exp_en` = 0, channels pass the first step unchanged.
- R6: With `clamp_en` = 1 and `clamp_fmt` equal to 1 (8 bpc), 2 (10 bpc) or 3 (12 bpc), each channel is limited to the range [256, hi]. The upper bound hi is 3775 for code 1, 3763 for code 2 and 3760 for code 3. This is 235 scaled to the depth, with the unused low bits set to ones.
- R7: With `clamp_en` = 0, or with `clamp_fmt` equal to 0 (full range), 4, 5, 6 or 7 (7 being a programmable range this block leaves as passthrough), channels pass the second step unchanged.
- R8: The limit is applied to the widened value, not to the raw input. For example, 0xEC0 widened from 8 bits with code 1 gives 3775.
- R9: The widening and limiting controls that apply to a pixel are those present in the cycle it is accepted, even when they change on every pixel.
- R10: When `out_valid` is 0, `out_data` keeps the value it last had.
- R11: Channel c occupies bits [12c+11 : 12c] of the data buses, and each channel is processed independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | NCH*12 | Input pixel, channel 0 in the low bits |
| exp_en | input | 1 | Widening request |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source |
| link_kind | input | 3 | Connector type code |
| clamp_en | input | 1 | Range limit enable |
| clamp_fmt | input | 3 | Range limit depth code |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | NCH*12 | Output pixel |

## Verification
The bench builds the block with its default of three channels, so the 12-bit code space is small enough to walk completely. Under several fixed control settings, every code from 0 to 4095 is driven on each channel. The three channels carry differing values at the same time, which exposes every rounding and bound edge of both steps and any crosstalk between channels. A further sweep steps through all 512 combinations of the control and link inputs, one pixel per cycle and interleaved with idle gaps. This brings per-pixel control capture and output holding within reach.

// File: rtl/rce_pkg.sv
package rce_pkg;

  localparam int PX_W      = 12;
  localparam int LINK_W    = 3;
  localparam int FMT_W     = 3;
  localparam int BASE_D    = 8;
  localparam int LIM_LO_B  = 16;
  localparam int LIM_HI_B  = 235;

  typedef logic [PX_W-1:0] px_t;

  localparam logic [LINK_W-1:0] LK_HDMI   = 3'd1;
  localparam logic [LINK_W-1:0] LK_DP_SST = 3'd2;
  localparam logic [LINK_W-1:0] LK_DP_MST = 3'd3;
  localparam logic [LINK_W-1:0] LK_VIRT   = 3'd4;

  localparam logic [FMT_W-1:0] CF_FULL = 3'd0;
  localparam logic [FMT_W-1:0] CF_D8   = 3'd1;
  localparam logic [FMT_W-1:0] CF_D10  = 3'd2;
  localparam logic [FMT_W-1:0] CF_D12  = 3'd3;
  localparam logic [FMT_W-1:0] CF_PROG = 3'd7;

  // Connector types that may carry widened data.
  function automatic logic link_allows_exp(logic [LINK_W-1:0] lk);
    logic ok;
    case (lk)
      LK_HDMI, LK_DP_SST, LK_DP_MST, LK_VIRT: ok = 1'b1;
      default:                                ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Keep the top 'depth' bits, refill the rest by repeating them downward.
  function automatic px_t widen(px_t x, int depth);
    px_t r;
    r = x;
    for (int i = PX_W - 1; i >= 0; i--) begin
      if (i < PX_W - depth) r[i] = r[i + depth];
    end
    return r;
  endfunction

  // Depth selected by a limit code; 0 means no limiting.
  function automatic int fmt_depth(logic [FMT_W-1:0] f);
    int d;
    case (f)
      CF_D8:   d = 8;
      CF_D10:  d = 10;
      CF_D12:  d = 12;
      default: d = 0;
    endcase
    return d;
  endfunction

  function automatic logic clamp_active(logic en, logic [FMT_W-1:0] f);
    return en && (fmt_depth(f) != 0);
  endfunction

  function automatic px_t range_lo(logic [FMT_W-1:0] f);
    int d;
    int v;
    d = fmt_depth(f);
    if (d == 0) return '0;
    v = (LIM_LO_B << (d - BASE_D)) << (PX_W - d);
    return px_t'(v);
  endfunction

  function automatic px_t range_hi(logic [FMT_W-1:0] f);
    int d;
    int sh;
    int v;
    d = fmt_depth(f);
    if (d == 0) return '1;
    sh = PX_W - d;
    v  = ((LIM_HI_B << (d - BASE_D)) << sh) | ((1 << sh) - 1);
    return px_t'(v);
  endfunction

endpackage

// File: rtl/rce_link_qual.sv
module rce_link_qual
  import rce_pkg::*;
(
  input  logic              exp_req,
  input  logic [LINK_W-1:0] link_kind,
  output logic              exp_go
);

  logic lk_ok;

  always_comb begin
    lk_ok  = link_allows_exp(link_kind);
    exp_go = exp_req && lk_ok;
  end

endmodule

// File: rtl/rce_expand_stage.sv
module rce_expand_stage
  import rce_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NCH*PX_W-1:0]   in_data,
  input  logic                  exp_go,
  input  logic                  exp_mode,
  input  logic                  clamp_en,
  input  logic [FMT_W-1:0]      clamp_fmt,
  output logic                  s1_valid,
  output logic [NCH*PX_W-1:0]   s1_data,
  output logic                  s1_cen,
  output logic [FMT_W-1:0]      s1_fmt
);

  localparam int BUS_W  = NCH * PX_W;
  localparam int SRC8   = 8;
  localparam int SRC10  = 10;

  logic [BUS_W-1:0] wide_nxt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    px_t raw;
    px_t wide;
    always_comb begin
      raw = in_data[c*PX_W +: PX_W];
      if (!exp_go)      wide = raw;
      else if (exp_mode) wide = widen(raw, SRC8);
      else              wide = widen(raw, SRC10);
    end
    assign wide_nxt[c*PX_W +: PX_W] = wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_cen   <= 1'b0;
      s1_fmt   <= CF_FULL;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_data <= wide_nxt;
        s1_cen  <= clamp_en;
        s1_fmt  <= clamp_fmt;
      end
    end
  end

endmodule

// File: rtl/rce_clamp_stage.sv
module rce_clamp_stage
  import rce_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic [NCH*PX_W-1:0]  s1_data,
  input  logic                 s1_cen,
  input  logic [FMT_W-1:0]     s1_fmt,
  output logic                 out_valid,
  output logic [NCH*PX_W-1:0]  out_data,
  output logic [NCH-1:0]       hit_lo,
  output logic [NCH-1:0]       hit_hi
);

  localparam int BUS_W = NCH * PX_W;

  logic             lim_on;
  px_t              lim_lo;
  px_t              lim_hi;
  logic [BUS_W-1:0] lim_nxt;

  // Bounds are shared by every channel of the pixel.
  always_comb begin
    lim_on = clamp_active(s1_cen, s1_fmt);
    lim_lo = range_lo(s1_fmt);
    lim_hi = range_hi(s1_fmt);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    px_t x;
    px_t y;
    always_comb begin
      x         = s1_data[c*PX_W +: PX_W];
      hit_lo[c] = lim_on && (x < lim_lo);
      hit_hi[c] = lim_on && (x > lim_hi);
      if (hit_lo[c])      y = lim_lo;
      else if (hit_hi[c]) y = lim_hi;
      else                y = x;
    end
    assign lim_nxt[c*PX_W +: PX_W] = y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= lim_nxt;
    end
  end

endmodule

// File: rtl/range_clamp_expand.sv
module range_clamp_expand
  import rce_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NCH*PX_W-1:0]  in_data,
  input  logic                 exp_en,
  input  logic                 exp_mode,
  input  logic [LINK_W-1:0]    link_kind,
  input  logic                 clamp_en,
  input  logic [FMT_W-1:0]     clamp_fmt,
  output logic                 out_valid,
  output logic [NCH*PX_W-1:0]  out_data
);

  logic                exp_go;
  logic                s1_valid;
  logic [NCH*PX_W-1:0] s1_data;
  logic                s1_cen;
  logic [FMT_W-1:0]    s1_fmt;
  logic [NCH-1:0]      hit_lo;
  logic [NCH-1:0]      hit_hi;

  rce_link_qual u_qual (
    .exp_req   (exp_en),
    .link_kind (link_kind),
    .exp_go    (exp_go)
  );

  rce_expand_stage #(.NCH(NCH)) u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .exp_go    (exp_go),
    .exp_mode  (exp_mode),
    .clamp_en  (clamp_en),
    .clamp_fmt (clamp_fmt),
    .s1_valid  (s1_valid),
    .s1_data   (s1_data),
    .s1_cen    (s1_cen),
    .s1_fmt    (s1_fmt)
  );

  rce_clamp_stage #(.NCH(NCH)) u_clamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_data   (s1_data),
    .s1_cen    (s1_cen),
    .s1_fmt    (s1_fmt),
    .out_valid (out_valid),
    .out_data  (out_data),
    .hit_lo    (hit_lo),
    .hit_hi    (hit_hi)
  );

endmodule

// File: rtl/rce_checker.sv
module rce_checker
  import rce_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [NCH*PX_W-1:0]  in_data,
  input logic                 exp_en,
  input logic                 exp_mode,
  input logic [LINK_W-1:0]    link_kind,
  input logic                 clamp_en,
  input logic [FMT_W-1:0]     clamp_fmt,
  input logic                 out_valid,
  input logic [NCH*PX_W-1:0]  out_data,
  input logic                 s1_valid,
  input logic [NCH*PX_W-1:0]  s1_data,
  input logic                 s1_cen,
  input logic [FMT_W-1:0]     s1_fmt,
  input logic [NCH-1:0]       hit_lo,
  input logic [NCH-1:0]       hit_hi
);

  p_lat_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  p_lat_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  p_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !(exp_en && link_allows_exp(link_kind)) |=> s1_data == $past(in_data));

  p_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_cen == $past(clamp_en)) && (s1_fmt == $past(clamp_fmt)));

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(clamp_active(s1_cen, s1_fmt)) |-> out_data == $past(s1_data));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_fill8_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && exp_en && link_allows_exp(link_kind) && exp_mode |=>
        (s1_data[c*PX_W +: 4] == s1_data[c*PX_W+8 +: 4]) &&
        (s1_data[c*PX_W+4 +: 8] == $past(in_data[c*PX_W+4 +: 8])));

    p_fill10_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && exp_en && link_allows_exp(link_kind) && !exp_mode |=>
        (s1_data[c*PX_W +: 2] == s1_data[c*PX_W+10 +: 2]) &&
        (s1_data[c*PX_W+2 +: 10] == $past(in_data[c*PX_W+2 +: 10])));

    p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(clamp_active(s1_cen, s1_fmt)) |->
        (out_data[c*PX_W +: PX_W] >= range_lo($past(s1_fmt))) &&
        (out_data[c*PX_W +: PX_W] <= range_hi($past(s1_fmt))));

    p_lo_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(hit_lo[c]) |-> out_data[c*PX_W +: PX_W] == range_lo($past(s1_fmt)));

    p_hi_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(hit_hi[c]) |-> out_data[c*PX_W +: PX_W] == range_hi($past(s1_fmt)));
  end

endmodule

bind range_clamp_expand rce_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .exp_en    (exp_en),
  .exp_mode  (exp_mode),
  .link_kind (link_kind),
  .clamp_en  (clamp_en),
  .clamp_fmt (clamp_fmt),
  .out_valid (out_valid),
  .out_data  (out_data),
  .s1_valid  (s1_valid),
  .s1_data   (s1_data),
  .s1_cen    (s1_cen),
  .s1_fmt    (s1_fmt),
  .hit_lo    (hit_lo),
  .hit_hi    (hit_hi)
);

// File: tb/range_clamp_expand_tb.sv
module range_clamp_expand_tb;

  localparam int NCH = 3;
  localparam int W   = 12;
  localparam int BW  = NCH * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [BW-1:0] in_data;
  logic          exp_en;
  logic          exp_mode;
  logic [2:0]    link_kind;
  logic          clamp_en;
  logic [2:0]    clamp_fmt;
  logic          out_valid;
  logic [BW-1:0] out_data;

  always #2 clk = ~clk;

  range_clamp_expand #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .exp_en(exp_en), .exp_mode(exp_mode), .link_kind(link_kind),
    .clamp_en(clamp_en), .clamp_fmt(clamp_fmt),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [BW-1:0] exp_q[$];
  string         tag_q[$];
  logic [BW-1:0] last_out;
  logic [1:0]    vh;

  task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Arithmetic model of the first step.
  function automatic int m_widen(int x, bit ee, bit em, int lk);
    int v;
    if (!ee || lk < 1 || lk > 4) return x;
    if (em) begin v = x / 16; return v * 16 + v / 16; end
    v = x / 4;
    return v * 4 + v / 256;
  endfunction

  // Arithmetic model of the second step.
  function automatic int m_limit(int x, bit ce, int cf);
    int hi;
    if (!ce) return x;
    case (cf)
      1: hi = 235 * 16 + 15;
      2: hi = 940 * 4 + 3;
      3: hi = 3760;
      default: return x;
    endcase
    if (x < 256) return 256;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic string m_tag(bit ee, bit em, int lk, bit ce, int cf);
    string a;
    string b;
    bit lim;
    bit wid;
    lim = ce && cf >= 1 && cf <= 3;
    wid = ee && lk >= 1 && lk <= 4;
    a = lim ? "R6" : "R7";
    if (wid) b = em ? "R3" : "R4";
    else     b = "R5";
    return $sformatf("%s %s", a, b);
  endfunction

  task automatic send(int c0, int c1, int c2, bit ee, bit em, int lk, bit ce, int cf,
                      string extra);
    logic [BW-1:0] e;
    int vals[3];
    vals[0] = c0; vals[1] = c1; vals[2] = c2;
    @(negedge clk);
    in_valid  = 1'b1;
    exp_en    = ee;
    exp_mode  = em;
    link_kind = 3'(lk);
    clamp_en  = ce;
    clamp_fmt = 3'(cf);
    for (int c = 0; c < NCH; c++) begin
      in_data[c*W +: W] = W'(vals[c]);
      e[c*W +: W] = W'(m_limit(m_widen(vals[c], ee, em, lk), ce, cf));
    end
    exp_q.push_back(e);
    tag_q.push_back({m_tag(ee, em, lk, ce, cf), " ", extra});
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic int corner(int i);
    case (i % 8)
      0: return 0;
      1: return 15;
      2: return 255;
      3: return 256;
      4: return 3760;
      5: return 3763;
      6: return 3775;
      default: return 4095;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vh <= 2'b00;
    else        vh <= {vh[0], in_valid};
  end

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk(out_valid == vh[1], "R2 valid delay", {{(BW-1){1'b0}}, out_valid},
          {{(BW-1){1'b0}}, vh[1]});
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected pixel", out_data, '0);
        end else begin
          logic [BW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, out_data, e);
        end
        last_out = out_data;
      end else begin
        chk(out_data == last_out, "R10 hold", out_data, last_out);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int cfg[7][5];
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; exp_en = 1'b0; exp_mode = 1'b0;
    link_kind = 3'd0; clamp_en = 1'b0; clamp_fmt = 3'd0; last_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R1 in reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R1 after release", out_data, '0);

    // Fixed-control full code sweeps: {exp_en, exp_mode, link, clamp_en, fmt}
    cfg[0] = '{1, 1, 1, 1, 1};
    cfg[1] = '{1, 0, 2, 1, 2};
    cfg[2] = '{1, 0, 3, 1, 3};
    cfg[3] = '{1, 1, 0, 0, 0};
    cfg[4] = '{0, 1, 1, 1, 7};
    cfg[5] = '{1, 1, 4, 1, 0};
    cfg[6] = '{1, 0, 5, 1, 1};
    for (int k = 0; k < 7; k++) begin
      for (int v = 0; v < 4096; v++) begin
        send(v, 4095 - v, (v * 37 + k * 911) % 4096, cfg[k][0][0], cfg[k][1][0],
             cfg[k][2], cfg[k][3][0], cfg[k][4], "R11");
      end
      idle(2);
    end

    // Every control combination, changing each pixel, with gaps.
    for (int rep = 0; rep < 8; rep++) begin
      for (int cmb = 0; cmb < 512; cmb++) begin
        send(corner(cmb + rep), corner(cmb + rep + 3), (rep * 517 + cmb * 91) % 4096,
             cmb[0], cmb[1], (cmb >> 2) & 7, cmb[5], (cmb >> 6) & 7, "R9");
        if (cmb % 5 == 4) idle(1 + rep % 3);
      end
    end

    // Limit after widening: 0xEC0 -> 0xECE -> 3775; 0x0F0 -> 256; 0xEB0 -> 0xEBE.
    send(12'hEC0, 12'h0F0, 12'hEB0, 1'b1, 1'b1, 1, 1'b1, 1, "R8");
    idle(4);
    chk(exp_q.size() == 0, "R2 all pixels emerged", BW'(exp_q.size()), '0);

    finished = 1;
    summary();
    $finish;
  end

endmodule